// File: doc/BRIEF.md
# Two-Wire Byte Master

This block is the bus-side core of a two-wire serial master. Software, through a separate register access path, moves the bus forward one event at a time. The events are START, repeated START, one byte out (address or data), one byte in, and STOP. Each event is launched by a write to the control register. When a byte or START event completes, the core sets an event flag and publishes an 8-bit status code that names the outcome. It then holds SCL low until software launches the next event by writing the control register with the flag bit clear.

Both lines are open-drain: the `sclOe`/`sdaOe` outputs pull a line low when high. Bit timing comes from an external rate tick. Each bit is four tick quarters long: SCL is low in the first quarter, high in the second and third, and low again in the fourth. SDA is sampled at the end of the third quarter. An interrupt line is raised while the interrupt enable input is high and the status is anything but idle. For recovery of a stuck bus, two force inputs let software pull either line low directly.

Top module: `twoWireMaster`

## Requirements
- R1: After reset the status reads 0xF8, the event flag (control bit 3) reads 0, both line drivers are released and the interrupt output is low.
- R2: A START request (control bit 5) from idle ends with status 0x08. From a held bus it ends with 0x10. Either way the flag is set and SCL is held low.
- R3: An address byte is sent from the data register, address in bits 7:1, direction in bit 0 (1 = read), MSB first. The status codes are: acknowledged write 0x18, unacknowledged write 0x20, acknowledged read 0x40, unacknowledged read 0x48.
- R4: A transmitted data byte goes out MSB first and ends with status 0x28 when acknowledged or 0x30 when not. The flag is set in both cases.
- R5: A received byte lands MSB first in the data register. With the acknowledge bit (control bit 2) set, the master drives ACK and the status is 0x50. With it clear, the master leaves SDA high (NACK) and the status is 0x58.
- R6: A STOP request (control bit 4) on a held bus releases both lines, returns the status to 0xF8 and leaves the flag clear.
- R7: The interrupt output is high exactly when the interrupt enable input is high and the status is not 0xF8.
- R8: A control write launches an event only when bus enable (bit 6) is 1 and flag bit 3 is written 0. A write with flag bit 3 = 1 leaves the flag and the bus untouched. A byte event is accepted only after status 0x08, 0x10, 0x18, 0x28, 0x40 or 0x50; after a NACK status, only START or STOP acts. STOP and byte requests from idle do nothing.
- R9: Control and data register writes that arrive while an event is in progress are ignored. A received byte is never overwritten by a data write that collides with its capture. Data writes while the bus is held take effect.
- R10: The SCL force input pulls SCL low and the SDA force input pulls SDA low, independently of the core state.
- R11: When START and STOP are requested in the same write, START wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclTick | input | 1 | Quarter-bit rate strobe from the rate generator |
| ctlWr | input | 1 | Control register write strobe |
| ctlWrData | input | 6 | Control write value, bits 7:2 (core enable, bus enable, START, STOP, flag, ack) |
| dataWr | input | 1 | Data register write strobe |
| dataWrData | input | BYTE_W | Data register write value |
| intEn | input | 1 | Interrupt enable |
| sclForce | input | 1 | Pull SCL low for bus recovery |
| sdaForce | input | 1 | Pull SDA low for bus recovery |
| sdaIn | input | 1 | Sensed SDA line level |
| ctlRdData | output | 8 | Control register readback (core enable, bus enable, flag, ack) |
| dataRdData | output | BYTE_W | Data register readback |
| statRdData | output | 8 | Status code |
| irq | output | 1 | Interrupt request |
| sclOe | output | 1 | SCL pull-down enable |
| sdaOe | output | 1 | SDA pull-down enable |

## Verification
Two functions can meet in one cycle: a data register write from software and the capture of a received byte at the end of its acknowledge bit. The bench provokes this by holding the data write strobe high, with a different value, for the whole receive. It also fires a STOP control write in the middle of the same receive. The result is judged by the received byte appearing intact in the data register and the status showing a completed receive rather than a stop. A second collision, START and STOP requested together, is judged by the resulting 0x08 status.

// File: rtl/twmPkg.sv
package twmPkg;
  // status codes seen by software
  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_TX_ACK  = 8'h28;
  localparam logic [7:0] ST_TX_NACK = 8'h30;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_RX_ACK  = 8'h50;
  localparam logic [7:0] ST_RX_NACK = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  // control bit positions
  localparam int CTL_CE  = 7;
  localparam int CTL_EN  = 6;
  localparam int CTL_STA = 5;
  localparam int CTL_STP = 4;
  localparam int CTL_FLG = 3;
  localparam int CTL_AAK = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_START, S_STOP, S_BYTE, S_ACK
  } twmState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadShift;
    logic sample;
    logic shift;
    logic storeRx;
  } dpStrobe_t;
endpackage

// File: rtl/twmDatapath.sv
module twmDatapath
  import twmPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              dataWrOk,
  input  logic [BYTE_W-1:0] dataWrVal,
  input  logic              sdaIn,
  output logic [BYTE_W-1:0] dataReg,
  output logic              txBit,
  output logic              lastBit,
  output logic              sampBit
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shiftQ, dataQ;
  logic [CNT_W-1:0]  cntQ;
  logic              sampQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      dataQ  <= '0;
      cntQ   <= '0;
      sampQ  <= 1'b1;
    end else begin
      if (strb.loadShift) begin
        shiftQ <= dataQ;
        cntQ   <= '0;
      end else if (strb.shift) begin
        shiftQ <= {shiftQ[BYTE_W-2:0], sampQ};
        cntQ   <= cntQ + 1'b1;
      end
      if (strb.sample) sampQ <= sdaIn;
      // capture of a received byte wins over a software write
      if (strb.storeRx)  dataQ <= shiftQ;
      else if (dataWrOk) dataQ <= dataWrVal;
    end
  end

  assign dataReg = dataQ;
  assign txBit   = shiftQ[BYTE_W-1];
  assign lastBit = (cntQ == LAST_IDX);
  assign sampBit = sampQ;
endmodule

// File: rtl/twmCtrl.sv
module twmCtrl
  import twmPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclTick,
  input  logic       ctlWr,
  input  logic [7:2] ctlWrVal,
  input  logic       addrRead,
  input  logic       txBit,
  input  logic       lastBit,
  input  logic       sampBit,
  output dpStrobe_t  strb,
  output logic [7:0] statOut,
  output logic [7:0] ctlOut,
  output logic       busy,
  output logic       sclLow,
  output logic       sdaLow
);
  twmState_t  stateQ;
  logic [1:0] qQ;
  logic [7:0] statQ;
  logic       ceQ, enQ, aakQ, flgQ, rdQ, addrQ;

  logic accept, go, held, stepOk, doStart, doStop, doByte, qEnd;
  logic txPhase, rxPhase, ackOk, fromStart;

  assign busy      = (stateQ == S_START) || (stateQ == S_STOP) ||
                     (stateQ == S_BYTE)  || (stateQ == S_ACK);
  assign held      = (stateQ == S_HOLD);
  assign accept    = ctlWr && !busy;
  assign go        = accept && ctlWrVal[CTL_EN] && !ctlWrVal[CTL_FLG];
  assign fromStart = (statQ == ST_START) || (statQ == ST_RSTART);
  assign stepOk    = fromStart || (statQ == ST_AW_ACK) || (statQ == ST_TX_ACK) ||
                     (statQ == ST_AR_ACK) || (statQ == ST_RX_ACK);
  assign doStart   = go && ctlWrVal[CTL_STA] && (stateQ == S_IDLE || held);
  assign doStop    = go && !ctlWrVal[CTL_STA] && ctlWrVal[CTL_STP] && held;
  assign doByte    = go && !ctlWrVal[CTL_STA] && !ctlWrVal[CTL_STP] && held && stepOk;
  assign qEnd      = sclTick && (qQ == 2'd3);
  assign txPhase   = addrQ || !rdQ;
  assign rxPhase   = !addrQ && rdQ;
  assign ackOk     = !sampBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      qQ     <= '0;
      statQ  <= ST_IDLE;
      ceQ    <= 1'b0;
      enQ    <= 1'b0;
      aakQ   <= 1'b0;
      flgQ   <= 1'b0;
      rdQ    <= 1'b0;
      addrQ  <= 1'b0;
    end else if (busy) begin
      if (sclTick) qQ <= qQ + 1'b1;
      if (qEnd) begin
        unique case (stateQ)
          S_START: begin
            stateQ <= S_HOLD;
            flgQ   <= 1'b1;
            statQ  <= (statQ == ST_IDLE) ? ST_START : ST_RSTART;
          end
          S_STOP: begin
            stateQ <= S_IDLE;
            statQ  <= ST_IDLE;
          end
          S_BYTE: if (lastBit) stateQ <= S_ACK;
          default: begin
            stateQ <= S_HOLD;
            flgQ   <= 1'b1;
            if (addrQ)
              statQ <= rdQ ? (ackOk ? ST_AR_ACK : ST_AR_NACK)
                           : (ackOk ? ST_AW_ACK : ST_AW_NACK);
            else if (rdQ)
              statQ <= aakQ ? ST_RX_ACK : ST_RX_NACK;
            else
              statQ <= ackOk ? ST_TX_ACK : ST_TX_NACK;
          end
        endcase
      end
    end else begin
      if (accept) begin
        ceQ  <= ctlWrVal[CTL_CE];
        enQ  <= ctlWrVal[CTL_EN];
        aakQ <= ctlWrVal[CTL_AAK];
        flgQ <= flgQ & ctlWrVal[CTL_FLG];
      end
      if (doStart || doStop || doByte) qQ <= '0;
      if (doStart)     stateQ <= S_START;
      else if (doStop) stateQ <= S_STOP;
      else if (doByte) begin
        stateQ <= S_BYTE;
        addrQ  <= fromStart;
        rdQ    <= fromStart ? addrRead : ((statQ == ST_AR_ACK) || (statQ == ST_RX_ACK));
      end
    end
  end

  always_comb begin
    strb.loadShift = doByte;
    strb.sample    = sclTick && (qQ == 2'd2) && ((stateQ == S_BYTE) || (stateQ == S_ACK));
    strb.shift     = qEnd && (stateQ == S_BYTE);
    strb.storeRx   = qEnd && (stateQ == S_ACK) && rxPhase;
  end

  always_comb begin
    sclLow = 1'b0;
    sdaLow = 1'b0;
    unique case (stateQ)
      S_HOLD:  sclLow = 1'b1;
      S_START: begin sclLow = (qQ == 2'd3); sdaLow = (qQ != 2'd0); end
      S_STOP:  begin sclLow = (qQ == 2'd0); sdaLow = (qQ < 2'd2);  end
      S_BYTE:  begin sclLow = (qQ == 2'd0) || (qQ == 2'd3); sdaLow = txPhase && !txBit; end
      S_ACK:   begin sclLow = (qQ == 2'd0) || (qQ == 2'd3); sdaLow = rxPhase && aakQ; end
      default: ;
    endcase
  end

  assign statOut = statQ;
  assign ctlOut  = {ceQ, enQ, 2'b00, flgQ, aakQ, 2'b00};
endmodule

// File: rtl/twoWireMaster.sv
module twoWireMaster
  import twmPkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclTick,
  input  logic              ctlWr,
  input  logic [7:2]        ctlWrData,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] dataWrData,
  input  logic              intEn,
  input  logic              sclForce,
  input  logic              sdaForce,
  input  logic              sdaIn,
  output logic [7:0]        ctlRdData,
  output logic [BYTE_W-1:0] dataRdData,
  output logic [7:0]        statRdData,
  output logic              irq,
  output logic              sclOe,
  output logic              sdaOe
);
  dpStrobe_t strb;
  logic busy, sclLow, sdaLow, txBit, lastBit, sampBit;

  twmCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclTick  (sclTick),
    .ctlWr    (ctlWr),
    .ctlWrVal (ctlWrData),
    .addrRead (dataRdData[0]),
    .txBit    (txBit),
    .lastBit  (lastBit),
    .sampBit  (sampBit),
    .strb     (strb),
    .statOut  (statRdData),
    .ctlOut   (ctlRdData),
    .busy     (busy),
    .sclLow   (sclLow),
    .sdaLow   (sdaLow)
  );

  twmDatapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dataWrOk  (dataWr && !busy),
    .dataWrVal (dataWrData),
    .sdaIn     (sdaIn),
    .dataReg   (dataRdData),
    .txBit     (txBit),
    .lastBit   (lastBit),
    .sampBit   (sampBit)
  );

  assign irq   = intEn && (statRdData != ST_IDLE);
  assign sclOe = sclLow || sclForce;
  assign sdaOe = sdaLow || sdaForce;
endmodule

// File: rtl/twmChk.sv
module twmChk (
  input logic       clk,
  input logic       rstN,
  input logic       sclOe,
  input logic       sdaOe,
  input logic       sclForce,
  input logic       sdaForce,
  input logic       irq,
  input logic       intEn,
  input logic [7:0] ctlRdData,
  input logic [7:0] statRdData
);
  // R2
  flag_holds_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlRdData[3]) |-> sclOe);

  // R8
  flag_freezes_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdData[3] |=> $stable(statRdData));

  // R6
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statRdData == 8'hF8) |-> !ctlRdData[3]);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (intEn && statRdData != 8'hF8));

  // R10
  scl_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    sclForce |-> sclOe);

  // R10
  sda_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    sdaForce |-> sdaOe);
endmodule

bind twoWireMaster twmChk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclOe      (sclOe),
  .sdaOe      (sdaOe),
  .sclForce   (sclForce),
  .sdaForce   (sdaForce),
  .irq        (irq),
  .intEn      (intEn),
  .ctlRdData  (ctlRdData),
  .statRdData (statRdData)
);

// File: tb/sim_twoWireMaster.sv
`timescale 1ns/1ps
module sim_twoWireMaster;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclTick = 1'b0;
  logic       ctlWr = 1'b0;
  logic [7:2] ctlWrData = '0;
  logic       dataWr = 1'b0;
  logic [7:0] dataWrData = '0;
  logic       intEn = 1'b0;
  logic       sclForce = 1'b0;
  logic       sdaForce = 1'b0;
  logic       sdaIn;
  logic [7:0] ctlRdData, dataRdData, statRdData;
  logic       irq, sclOe, sdaOe;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  twoWireMaster u0 (
    .clk(clk), .rstN(rstN), .sclTick(sclTick), .ctlWr(ctlWr), .ctlWrData(ctlWrData),
    .dataWr(dataWr), .dataWrData(dataWrData), .intEn(intEn), .sclForce(sclForce),
    .sdaForce(sdaForce), .sdaIn(sdaIn), .ctlRdData(ctlRdData), .dataRdData(dataRdData),
    .statRdData(statRdData), .irq(irq), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  // ---------------- slave model ----------------
  localparam logic [6:0] SLV_ADDR = 7'h2A;
  localparam int M_IDLE = 0, M_ADDR = 1, M_WR = 2, M_RD = 3;
  logic       slvLow = 1'b0;
  logic       prevScl = 1'b1, prevSda = 1'b1;
  logic       sclL, sdaL, isRd = 1'b0, mAck = 1'b0;
  logic [7:0] sh = '0, txb = '0;
  logic [7:0] wrLog [0:7];
  int mode = M_IDLE, cnt = 0, nWr = 0, wrLimit = 99, rdIdx = 0, ackCnt = 0;

  assign sdaIn = ~(sdaOe | slvLow);

  function automatic logic [7:0] rdByte(input int i);
    return 8'hC3 ^ (8'(i) * 8'h1D);
  endfunction

  always @(negedge clk) begin
    sclL = ~sclOe;
    sdaL = ~(sdaOe | slvLow);
    if (sclL && prevScl && prevSda && !sdaL) begin
      mode = M_ADDR; cnt = 0; slvLow = 1'b0;
    end else if (sclL && prevScl && !prevSda && sdaL) begin
      mode = M_IDLE; slvLow = 1'b0;
    end else if (sclL && !prevScl) begin
      if (mode == M_ADDR || mode == M_WR) begin
        if (cnt < 8) sh = {sh[6:0], sdaL};
        cnt++;
      end else if (mode == M_RD) begin
        if (cnt == 8) begin mAck = !sdaL; if (mAck) ackCnt++; end
        cnt++;
      end
    end else if (!sclL && prevScl) begin
      if (mode == M_ADDR) begin
        if (cnt == 8) begin
          if (sh[7:1] == SLV_ADDR) begin slvLow = 1'b1; isRd = sh[0]; end
          else mode = M_IDLE;
        end else if (cnt == 9) begin
          slvLow = 1'b0; cnt = 0;
          if (isRd) begin mode = M_RD; rdIdx = 0; txb = rdByte(0); slvLow = ~txb[7]; end
          else mode = M_WR;
        end
      end else if (mode == M_WR) begin
        if (cnt == 8) begin
          if (nWr < 8) wrLog[nWr] = sh;
          nWr++;
          if (nWr <= wrLimit) slvLow = 1'b1;
        end else if (cnt == 9) begin
          slvLow = 1'b0; cnt = 0;
        end
      end else if (mode == M_RD) begin
        if (cnt >= 1 && cnt <= 7) slvLow = ~txb[7-cnt];
        else if (cnt == 8) slvLow = 1'b0;
        else if (cnt == 9) begin
          if (mAck) begin rdIdx++; txb = rdByte(rdIdx); slvLow = ~txb[7]; cnt = 0; end
          else begin slvLow = 1'b0; mode = M_IDLE; end
        end
      end
    end
    prevScl = sclL;
    prevSda = ~(sdaOe | slvLow);
  end

  // quarter-bit strobe, one cycle in four
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      sclTick = 1'b1;
      @(negedge clk);
      sclTick = 1'b0;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrCtl(input logic [7:0] v);
    @(negedge clk); ctlWr = 1'b1; ctlWrData = v[7:2];
    @(negedge clk); ctlWr = 1'b0;
  endtask

  task automatic wrData(input logic [7:0] v);
    @(negedge clk); dataWr = 1'b1; dataWrData = v;
    @(negedge clk); dataWr = 1'b0;
  endtask

  task automatic waitFlag(input string req);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (ctlRdData[3]) seen = 1'b1;
    end
    check(req, "flag set", 32'(seen), 32'd1);
  endtask

  task automatic stepExpect(input string req, input logic [7:0] ctl, input logic [7:0] stat);
    wrCtl(ctl);
    waitFlag(req);
    check(req, "status", 32'(statRdData), 32'(stat));
  endtask

  task automatic doStop();
    wrCtl(8'h50);
    repeat (60) @(negedge clk);
    check("R6", "stop status", 32'(statRdData), 32'hF8);
    check("R6", "stop flag", 32'(ctlRdData[3]), 32'd0);
    check("R6", "lines free", 32'({sclOe, sdaOe}), 32'd0);
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    check("R1", "status", 32'(statRdData), 32'hF8);
    check("R1", "flag", 32'(ctlRdData[3]), 32'd0);
    check("R1", "lines", 32'({sclOe, sdaOe}), 32'd0);
    check("R1", "irq", 32'(irq), 32'd0);
  endtask

  task automatic tWrite();
    nWr = 0;
    intEn = 1'b1;
    stepExpect("R2", 8'h60, 8'h08);
    check("R2", "scl held", 32'(sclOe), 32'd1);
    check("R7", "irq on", 32'(irq), 32'd1);
    wrData(8'h54);
    stepExpect("R3", 8'h40, 8'h18);
    wrData(8'hA5);
    stepExpect("R4", 8'h40, 8'h28);
    wrData(8'h3C);
    stepExpect("R4", 8'h40, 8'h28);
    check("R4", "slave byte0", 32'(wrLog[0]), 32'hA5);
    check("R4", "slave byte1", 32'(wrLog[1]), 32'h3C);
    doStop();
    check("R7", "irq off at idle", 32'(irq), 32'd0);
    intEn = 1'b0;
    wrCtl(8'h60);
    waitFlag("R7");
    check("R7", "irq masked", 32'(irq), 32'd0);
    doStop();
  endtask

  task automatic tRead();
    ackCnt = 0;
    stepExpect("R2", 8'h60, 8'h08);
    wrData(8'h55);
    stepExpect("R3", 8'h40, 8'h40);
    stepExpect("R5", 8'h44, 8'h50);
    check("R5", "rx byte0", 32'(dataRdData), 32'(rdByte(0)));
    stepExpect("R5", 8'h40, 8'h58);
    check("R5", "rx byte1", 32'(dataRdData), 32'(rdByte(1)));
    check("R5", "master acks seen", 32'(ackCnt), 32'd1);
    doStop();
  endtask

  task automatic tRestart();
    stepExpect("R2", 8'h60, 8'h08);
    wrData(8'h54);
    stepExpect("R3", 8'h40, 8'h18);
    stepExpect("R2", 8'h60, 8'h10);
    wrData(8'h55);
    stepExpect("R3", 8'h40, 8'h40);
    stepExpect("R5", 8'h40, 8'h58);
    check("R5", "rx after restart", 32'(dataRdData), 32'(rdByte(0)));
    doStop();
  endtask

  task automatic tAddrNack();
    intEn = 1'b1;
    stepExpect("R2", 8'h60, 8'h08);
    wrData(8'h40);
    stepExpect("R3", 8'h40, 8'h20);
    check("R7", "irq on nack", 32'(irq), 32'd1);
    wrCtl(8'h40);  // byte step after NACK: must not act
    repeat (150) @(negedge clk);
    check("R8", "status kept", 32'(statRdData), 32'h20);
    check("R8", "scl still held", 32'(sclOe), 32'd1);
    stepExpect("R2", 8'h60, 8'h10);
    wrData(8'h41);
    stepExpect("R3", 8'h40, 8'h48);
    doStop();
    intEn = 1'b0;
  endtask

  task automatic tDataNack();
    nWr = 0; wrLimit = 1;
    stepExpect("R2", 8'h60, 8'h08);
    wrData(8'h54);
    stepExpect("R3", 8'h40, 8'h18);
    wrData(8'hA1);
    stepExpect("R4", 8'h40, 8'h28);
    wrData(8'hB2);
    stepExpect("R4", 8'h40, 8'h30);
    check("R4", "nacked byte seen", 32'(wrLog[1]), 32'hB2);
    doStop();
    wrLimit = 99;
  endtask

  task automatic tIgnored();
    wrCtl(8'h20);  // START without bus enable
    repeat (80) @(negedge clk);
    check("R8", "no enable: status", 32'(statRdData), 32'hF8);
    check("R8", "no enable: lines", 32'({sclOe, sdaOe}), 32'd0);
    wrCtl(8'h68);  // START with flag bit written 1
    repeat (80) @(negedge clk);
    check("R8", "flag=1: status", 32'(statRdData), 32'hF8);
    check("R8", "flag=1: lines", 32'({sclOe, sdaOe}), 32'd0);
    wrCtl(8'h40);  // byte from idle
    wrCtl(8'h50);  // stop from idle
    repeat (80) @(negedge clk);
    check("R8", "idle byte/stop", 32'({statRdData, sclOe, sdaOe}), 32'({8'hF8, 2'b00}));
    stepExpect("R2", 8'h60, 8'h08);
    wrData(8'h54);
    wrCtl(8'h48);  // flag bit 1: no step, flag stays
    repeat (150) @(negedge clk);
    check("R8", "held flag=1: status", 32'(statRdData), 32'h08);
    check("R8", "held flag=1: flag", 32'(ctlRdData[3]), 32'd1);
    stepExpect("R8", 8'h40, 8'h18);
    doStop();
  endtask

  task automatic tBusy();
    logic seen;
    stepExpect("R2", 8'h60, 8'h08);
    wrData(8'h55);
    stepExpect("R3", 8'h40, 8'h40);
    wrCtl(8'h44);
    @(negedge clk);
    dataWr = 1'b1; dataWrData = 8'h00;
    ctlWr = 1'b1; ctlWrData = 6'h14;  // STOP while busy
    @(negedge clk);
    ctlWr = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (ctlRdData[3]) seen = 1'b1;
    end
    dataWr = 1'b0;
    check("R9", "flag after busy writes", 32'(seen), 32'd1);
    check("R9", "stop ignored", 32'(statRdData), 32'h50);
    check("R9", "rx kept", 32'(dataRdData), 32'(rdByte(0)));
    wrData(8'h77);
    check("R9", "held data write", 32'(dataRdData), 32'h77);
    stepExpect("R5", 8'h40, 8'h58);
    check("R5", "second rx", 32'(dataRdData), 32'(rdByte(1)));
    doStop();
  endtask

  task automatic tBoth();
    stepExpect("R11", 8'h70, 8'h08);
    doStop();
  endtask

  task automatic tForce();
    @(negedge clk); sclForce = 1'b1; #1;
    check("R10", "scl forced", 32'({sclOe, sdaOe}), 32'b10);
    @(negedge clk); sclForce = 1'b0; sdaForce = 1'b1; #1;
    check("R10", "sda forced", 32'({sclOe, sdaOe}), 32'b01);
    @(negedge clk); sdaForce = 1'b0; #1;
    check("R10", "released", 32'({sclOe, sdaOe}), 32'b00);
    check("R10", "status untouched", 32'(statRdData), 32'hF8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tWrite();
    tRead();
    tRestart();
    tAddrNack();
    tDataNack();
    tIgnored();
    tBusy();
    tBoth();
    tForce();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule